// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a processor's store path and a memory write channel. Stores are accepted into a small ordered queue and are not sent on at once. The queue collects entries until one of three triggers starts a drain: occupancy reaches a threshold, the queue has gone a set number of cycles without a new store, or a fence is requested. A drain then runs as one batch and sends the oldest entry first, one write at a time, until the queue is empty. Each write is complete only when memory returns an acknowledgement.

When a store names an address that already has a pending entry, the block overwrites that entry's data in place. It does not add a second entry, so memory receives only the latest value. The entry that is currently presented to memory is locked against this kind of merge. A store to the locked entry's address joins the tail as a new entry.

A fence request stops the acceptance of new stores and forces a drain. The block raises its completion output only once every store accepted before the fence has been acknowledged by memory.

Top module: `store_absorb_buffer`

## Requirements
- R1: After reset, st_ready is high, mem_wr_valid is low, fence_done is low and the queue holds no entries.
- R2: An accepted store is not presented to memory while the block is collecting. Collecting ends only when a drain trigger fires.
- R3: A store that brings occupancy to DRAIN_THRESH is accepted at some clock edge. mem_wr_valid is low after that edge and high after the next one.
- R4: Suppose a single store is accepted at edge E0 into an empty queue and nothing follows it. mem_wr_valid stays low through edge E0+IDLE_LIMIT and is high after edge E0+IDLE_LIMIT+1.
- R5: Once a drain has started, mem_wr_valid stays high from one write to the next until the queue is empty. It then goes low, and the block returns to collecting.
- R6: A store to an address held by a pending entry that is not presented to memory replaces that entry's data. Occupancy is unchanged, and only the last value reaches memory.
- R7: While mem_wr_valid is high and no acknowledgement has arrived, mem_wr_addr and mem_wr_data do not change. A store to that address is appended as a new entry, which is written after the presented one.
- R8: Entries with distinct addresses are written to memory in the order in which their first pending store was accepted.
- R9: When all DEPTH entries are occupied, st_ready is low for an address with no mergeable entry. It is high for an address that has one.
- R10: While fence_req is high, st_ready is low and a drain is forced. fence_done is high only once every earlier store has been acknowledged, and it stays high while fence_req is held.
- R11: An entry leaves the queue only on a cycle where mem_wr_valid and mem_wr_ack are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| mem_wr_valid | output | 1 | Write presented to memory |
| mem_wr_addr | output | ADDR_W | Write address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Memory has installed the presented write |
| fence_req | input | 1 | Fence request, held until fence_done |
| fence_done | output | 1 | All stores before the fence are installed |

## Verification
Two functions can land on the same clock edge: a store being accepted and the head entry being retired by an acknowledgement. When they coincide, the queue must shift and then either merge the store into an entry whose index moves down by one or append it at the shortened tail. The bench provokes this coincidence in two ways. It releases a held acknowledgement while a store is waiting on a full queue, and it sweeps store patterns over a small set of addresses with the memory latency varied between zero and two cycles. The outcome is judged from the ports: after every fence, the bench compares the memory image rebuilt from observed writes against the last value stored to each address, and it checks the order of the logged writes.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  typedef enum logic [0:0] {
    SB_COLLECT = 1'b0,
    SB_DRAIN   = 1'b1
  } sb_mode_e;
endpackage

// File: rtl/sb_addr_match.sv
`timescale 1ns/1ps
module sb_addr_match #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  input  logic [DEPTH-1:0]             slot_vld,
  input  logic [ADDR_W-1:0]            probe_addr,
  input  logic                         head_locked,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  logic [DEPTH-1:0] eq_vec;

  // One comparator per slot; slot 0 is excluded while it is on the memory port.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq_vec[g] = slot_vld[g] && (slot_addr[g] == probe_addr) &&
                       ((g != 0) || !head_locked);
  end

  // Youngest match wins: only the presented head can duplicate an address.
  always_comb begin
    hit     = |eq_vec;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eq_vec[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sb_entry_queue.sv
`timescale 1ns/1ps
module sb_entry_queue #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_absorb,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         pop,
  output logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
  output logic [DEPTH-1:0]             slot_vld,
  output logic [ADDR_W-1:0]            head_addr,
  output logic [DATA_W-1:0]            head_data,
  output logic [CNT_W-1:0]             count
);
  logic [DEPTH-1:0][DATA_W-1:0] slot_data;
  logic [DEPTH-1:0][ADDR_W-1:0] nxt_addr;
  logic [DEPTH-1:0][DATA_W-1:0] nxt_data;
  logic [DEPTH-1:0]             nxt_vld;
  logic                         upd_en;

  assign upd_en    = wr_en | pop;
  assign head_addr = slot_addr[0];
  assign head_data = slot_data[0];

  always_comb begin
    count = '0;
    for (int i = 0; i < DEPTH; i++) begin
      count = count + CNT_W'(slot_vld[i]);
    end
  end

  // Next state: shift on retire, then merge or append the incoming store.
  always_comb begin
    int tail_pos;
    int dest_pos;
    nxt_addr = slot_addr;
    nxt_data = slot_data;
    nxt_vld  = slot_vld;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        nxt_addr[i] = slot_addr[i+1];
        nxt_data[i] = slot_data[i+1];
        nxt_vld[i]  = slot_vld[i+1];
      end
      nxt_vld[DEPTH-1] = 1'b0;
    end
    tail_pos = int'(count) - (pop ? 1 : 0);
    dest_pos = int'(wr_idx) - (pop ? 1 : 0);
    for (int j = 0; j < DEPTH; j++) begin
      if (wr_en && wr_absorb && (j == dest_pos)) begin
        nxt_data[j] = wr_data;
      end
      if (wr_en && !wr_absorb && (j == tail_pos)) begin
        nxt_addr[j] = wr_addr;
        nxt_data[j] = wr_data;
        nxt_vld[j]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld <= '0;
    end else if (upd_en) begin
      slot_vld <= nxt_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      slot_addr <= nxt_addr;
      slot_data <= nxt_data;
    end
  end

  AST_ABSORB_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_absorb && !pop |=> count == $past(count)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_absorb |-> count < CNT_W'(DEPTH)); // R9
  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> slot_vld[0]); // R11
endmodule

// File: rtl/sb_drain_ctrl.sv
`timescale 1ns/1ps
module sb_drain_ctrl
  import sb_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int DRAIN_THRESH = 6,
  parameter int IDLE_LIMIT   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             st_fire,
  input  logic             fence_req,
  output logic             draining,
  output logic             fence_done
);
  localparam int TMR_W = $clog2(IDLE_LIMIT + 1);

  sb_mode_e         mode_q, mode_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             go_drain;
  logic             non_empty;

  assign non_empty = (count != '0);
  assign go_drain  = non_empty &&
                     ((count >= CNT_W'(DRAIN_THRESH)) || fence_req ||
                      (tmr_q >= TMR_W'(IDLE_LIMIT)));

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      SB_COLLECT: if (go_drain)   mode_d = SB_DRAIN;
      SB_DRAIN:   if (!non_empty) mode_d = SB_COLLECT;
      default:    mode_d = SB_COLLECT;
    endcase
  end

  // Quiet-cycle counter: runs only while collecting a non-empty queue.
  always_comb begin
    tmr_d = '0;
    if ((mode_q == SB_COLLECT) && non_empty && !st_fire) begin
      tmr_d = (tmr_q >= TMR_W'(IDLE_LIMIT)) ? tmr_q : tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SB_COLLECT;
      tmr_q  <= '0;
    end else begin
      mode_q <= mode_d;
      tmr_q  <= tmr_d;
    end
  end

  assign draining   = (mode_q == SB_DRAIN);
  assign fence_done = fence_req && !non_empty;
endmodule

// File: rtl/store_absorb_buffer.sv
`timescale 1ns/1ps
module store_absorb_buffer #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 8,
  parameter int DRAIN_THRESH = 6,
  parameter int IDLE_LIMIT   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  input  logic              fence_req,
  output logic              fence_done
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0]             slot_vld;
  logic [CNT_W-1:0]             count;
  logic                         hit;
  logic [IDX_W-1:0]             hit_idx;
  logic                         draining;
  logic                         st_fire;
  logic                         pop;

  assign st_ready     = !fence_req && ((count < CNT_W'(DEPTH)) || hit);
  assign st_fire      = st_valid && st_ready;
  assign mem_wr_valid = draining && (count != '0);
  assign pop          = mem_wr_valid && mem_wr_ack;

  sb_addr_match #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) match_i (
    .slot_addr  (slot_addr),
    .slot_vld   (slot_vld),
    .probe_addr (st_addr),
    .head_locked(mem_wr_valid),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  sb_entry_queue #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) queue_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_fire),
    .wr_absorb(hit),
    .wr_idx   (hit_idx),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .pop      (pop),
    .slot_addr(slot_addr),
    .slot_vld (slot_vld),
    .head_addr(mem_wr_addr),
    .head_data(mem_wr_data),
    .count    (count)
  );

  sb_drain_ctrl #(
    .CNT_W(CNT_W), .DRAIN_THRESH(DRAIN_THRESH), .IDLE_LIMIT(IDLE_LIMIT)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .st_fire   (st_fire),
    .fence_req (fence_req),
    .draining  (draining),
    .fence_done(fence_done)
  );

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_addr) &&
    $stable(mem_wr_data)); // R7
  AST_BATCH_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ack && (count > CNT_W'(1)) |=> mem_wr_valid); // R5
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> !mem_wr_valid); // R10
  AST_FENCE_WAITS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req && mem_wr_valid && !mem_wr_ack |=> !fence_done); // R10
endmodule

// File: tb/store_absorb_buffer_tb_top.sv
`timescale 1ns/1ps
module store_absorb_buffer_tb_top;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int DEP = 4;
  localparam int THR = 3;
  localparam int IDL = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          st_ready;
  logic          mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ack;
  logic          fence_req;
  logic          fence_done;

  always #2.5 clk = ~clk;

  store_absorb_buffer #(
    .ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP), .DRAIN_THRESH(THR), .IDLE_LIMIT(IDL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .fence_req(fence_req), .fence_done(fence_done)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit run_over = 1'b0;

  int ack_delay = 0;
  bit ack_hold  = 1'b0;
  int wait_cnt  = 0;
  int wn        = 0;
  int wlog_a [0:255];
  int wlog_d [0:255];
  int mem_img [0:15];

  // Memory model: acknowledges after ack_delay observed cycles and logs the write.
  initial begin
    mem_wr_ack = 1'b0;
    for (int k = 0; k < 16; k++) mem_img[k] = 0;
    forever begin
      @(negedge clk);
      if (mem_wr_ack) begin
        mem_wr_ack = 1'b0;
        wait_cnt   = 0;
      end else if (mem_wr_valid && !ack_hold) begin
        if (wait_cnt >= ack_delay) begin
          mem_wr_ack = 1'b1;
          if (wn < 256) begin
            wlog_a[wn] = int'(mem_wr_addr);
            wlog_d[wn] = int'(mem_wr_data);
          end
          wn = wn + 1;
          mem_img[mem_wr_addr] = int'(mem_wr_data);
        end else begin
          wait_cnt = wait_cnt + 1;
        end
      end
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!run_over) begin
      run_over = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic do_store(input int a, input int d);
    @(negedge clk);
    st_valid = 1'b1;
    st_addr  = AW'(a);
    st_data  = DW'(d);
    #1;
    for (int g = 0; g < 300 && !st_ready; g++) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    st_valid = 1'b0;
  endtask

  task automatic do_fence(input string req, input int exp_writes, output int waited);
    waited = 0;
    @(negedge clk);
    fence_req = 1'b1;
    #1;
    chk_eq({req, " st_ready low during fence"}, int'(st_ready), 0);
    while (!fence_done && waited < 400) begin
      @(negedge clk);
      #1;
      waited++;
    end
    chk_eq({req, " fence_done raised"}, int'(fence_done), 1);
    if (exp_writes >= 0) chk_eq({req, " writes acked at fence_done"}, wn, exp_writes);
    @(negedge clk);
    #1;
    chk_eq({req, " fence_done held"}, int'(fence_done), 1);
    fence_req = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #1;
    wn = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int waited;
    int gaps;
    int model [0:15];
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; fence_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    chk_eq("R1 st_ready", int'(st_ready), 1);
    chk_eq("R1 mem_wr_valid", int'(mem_wr_valid), 0);
    chk_eq("R1 fence_done", int'(fence_done), 0);

    // R2 / R4: idle timeout launches a lone store
    settle();
    ack_delay = 0;
    do_store(3, 8'h11);
    for (int k = 0; k <= IDL; k++) begin
      @(negedge clk);
      #1;
      chk_eq("R2 held while collecting", int'(mem_wr_valid), 0);
    end
    @(negedge clk);
    #1;
    chk_eq("R4 valid after idle limit", int'(mem_wr_valid), 1);
    chk_eq("R4 addr", int'(mem_wr_addr), 3);
    chk_eq("R4 data", int'(mem_wr_data), 8'h11);
    repeat (3) @(negedge clk);
    #1;
    chk_eq("R11 one write", wn, 1);

    // R6: three stores to one address merge into one write
    settle();
    do_store(5, 8'h21);
    do_store(5, 8'h22);
    do_store(5, 8'h23);
    do_fence("R10 merge", 1, waited);
    chk_eq("R6 merged value", wlog_d[0], 8'h23);

    // R3 / R5 / R8: threshold start, batch, issue order
    settle();
    ack_delay = 1;
    do_store(1, 8'h31);
    do_store(2, 8'h32);
    do_store(1, 8'h33);
    do_store(4, 8'h34);
    @(negedge clk);
    #1;
    chk_eq("R3 not before next edge", int'(mem_wr_valid), 0);
    @(negedge clk);
    #1;
    chk_eq("R3 valid after threshold", int'(mem_wr_valid), 1);
    gaps = 0;
    for (int g = 0; g < 60 && wn < 3; g++) begin
      @(negedge clk);
      #1;
      if (!mem_wr_valid && wn < 3) gaps++;
    end
    chk_eq("R5 no gap inside batch", gaps, 0);
    repeat (3) @(negedge clk);
    #1;
    chk_eq("R5 idle after batch", int'(mem_wr_valid), 0);
    chk_eq("R8 write count", wn, 3);
    chk_eq("R8 first addr", wlog_a[0], 1);
    chk_eq("R6 first data", wlog_d[0], 8'h33);
    chk_eq("R8 second addr", wlog_a[1], 2);
    chk_eq("R8 third addr", wlog_a[2], 4);

    // R7 / R9 / R11: full queue with the head held at memory
    settle();
    ack_delay = 0;
    ack_hold  = 1'b1;
    do_store(8, 1);
    do_store(9, 2);
    do_store(10, 3);
    do_store(11, 4);
    @(negedge clk);
    st_valid = 1'b1; st_addr = AW'(12); st_data = 8'h55;
    #1;
    chk_eq("R9 full, no match", int'(st_ready), 0);
    st_addr = AW'(8);
    #1;
    chk_eq("R7 head not mergeable", int'(st_ready), 0);
    st_addr = AW'(10);
    #1;
    chk_eq("R9 full, match", int'(st_ready), 1);
    st_valid = 1'b0;
    do_store(10, 8'h33);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      #1;
      chk_eq("R7 head addr held", int'(mem_wr_addr), 8);
      chk_eq("R7 head data held", int'(mem_wr_data), 1);
    end
    chk_eq("R11 no write without ack", wn, 0);
    ack_hold = 1'b0;
    do_store(8, 8'h44);
    do_fence("R10 full", 5, waited);
    chk_eq("R8 w0 addr", wlog_a[0], 8);
    chk_eq("R7 w0 data", wlog_d[0], 1);
    chk_eq("R8 w1 addr", wlog_a[1], 9);
    chk_eq("R6 w2 data", wlog_d[2], 8'h33);
    chk_eq("R8 w3 addr", wlog_a[3], 11);
    chk_eq("R7 w4 addr", wlog_a[4], 8);
    chk_eq("R7 w4 data", wlog_d[4], 8'h44);

    // R10: fence with slow memory, then on an empty queue
    settle();
    ack_delay = 3;
    do_store(2, 8'h55);
    do_store(6, 8'h66);
    do_fence("R10 slow", 2, waited);
    settle();
    do_fence("R10 empty", 0, waited);
    chk_eq("R10 empty fence immediate", waited, 0);

    // Sweep: store patterns over four addresses, varied memory latency
    for (int p = 0; p < 12; p++) begin
      settle();
      ack_delay = p % 3;
      for (int k = 12; k < 16; k++) model[k] = mem_img[k];
      for (int i = 0; i < 7; i++) begin
        int a;
        int d;
        a = 12 + ((p + i * (p | 1)) % 4);
        d = (p * 8 + i + 1) & 8'hFF;
        do_store(a, d);
        model[a] = d;
      end
      do_fence("R10 sweep", -1, waited);
      for (int k = 12; k < 16; k++) begin
        chk_eq("R6 sweep image", mem_img[k], model[k]);
      end
    end

    finish_run();
  end
endmodule